// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven management master for Ethernet PHYs. A host holds two 16-bit registers: a data register and a control register. Writing the control register launches one clause-22 management transaction on the MDC/MDIO pair. That transaction is either a read or a write of one PHY register. The host then polls a finish flag until the transaction is over.

For a write, the host loads the data register first. Its contents are shifted out in the data phase of the frame. For a read, the data phase is driven by the PHY. The block releases its MDIO output enable for the turnaround and the data bits, and shifts the returned bits into the data register. The host reads them from there once the finish flag is high.

MDC is derived from the system clock by a parameterised divider and runs only during a transfer. MDIO changes on the falling MDC edge and is sampled on the rising edge. The incoming MDIO line passes through a parameterised number of synchroniser stages. Only one command can be in flight at a time. Register writes that arrive during a transfer are dropped.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command fields are taken from the control word: PHY address from bits 12:8, register number from bits 4:0, and bit 13 set for write or clear for read. Reading the control register (rd_sel=1) returns {finish, 0, write bit, PHY address, 000, register number}.
- R2: Each transfer emits PRE_LEN ones, then start 01, then opcode 10 for read or 01 for write, then the 5-bit PHY address, then the 5-bit register number, then a 2-bit turnaround, then 16 data bits. Every field is sent MSB first. For a write the turnaround is 10.
- R3: For a write, the 16 data bits sent are the data register contents, which the host loads with wr_sel=0 before the control write.
- R4: The finish flag is bit 15 of the control readback. It goes low in the cycle after an accepted control write. It stays low for 2*(PRE_LEN+32)*CLK_DIV cycles counted from that accepting edge, then returns high.
- R5: After a read completes, the data register (rd_sel=0) holds the 16 bits the PHY drove in the data phase. They are taken MSB first, one on each rising MDC edge.
- R6: mdio_oe is high for every bit of a write and for the first PRE_LEN+14 bits of a read. It is low for the read turnaround and data bits, and low whenever the block is idle.
- R7: MDC is low when idle. During a transfer it toggles every CLK_DIV system clocks, starting with a rise CLK_DIV cycles after the accepting edge. mdio_o and mdio_oe never change on a rising MDC edge.
- R8: Any register write (control or data) while the finish flag is low is ignored. The frame in flight, the latched command, the data register and the finish flag are unaffected, and no second transfer follows.
- R9: After reset, the finish flag is high, the data register reads 0, the control readback reads 16'h8000, and MDC and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 data register, 1 control register |
| wr_data | input | 16 | Write value |
| rd_sel | input | 1 | Read source: 0 data register, 1 control readback |
| rd_data | output | 16 | Selected register value (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high drives the line) |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
The finish flag is due low on the read-back half a cycle after the accepting edge. It must still be low 2*(PRE_LEN+32)*CLK_DIV-1 cycles later and must be high one cycle after that. The bench counts falling system-clock edges from the accepting edge and samples at exactly those two points. The PHY model captures mdio_o and mdio_oe on each rising MDC edge and changes mdio_i two nanoseconds after each falling MDC edge, so each value is stable long before the block samples it. Register contents are read through the combinational read port only after the finish flag has been observed high. Writes during a transfer are injected at a fixed cycle in mid-frame, and their lack of effect is judged from the captured frame, the count of MDC rises and the final readback.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int PHY_W   = 5;
   localparam int REG_W   = 5;
   localparam int DATA_W  = 16;
   // control word bit positions (host visible)
   localparam int PHY_LSB = 8;
   localparam int REG_LSB = 0;
   localparam int WR_BIT  = 13;
   localparam int FIN_BIT = 15;
   // frame bits following the preamble: start, op, addresses, turnaround, data
   localparam int HDR_W   = 2 + 2 + PHY_W + REG_W;
   localparam int BODY_W  = HDR_W + 2 + DATA_W;

   typedef struct packed {
      logic             wr;
      logic [PHY_W-1:0] phy;
      logic [REG_W-1:0] rg;
   } mdio_cmd_t;

   function automatic mdio_cmd_t decode_ctrl(input logic [DATA_W-1:0] w);
      mdio_cmd_t c;
      c.wr  = w[WR_BIT];
      c.phy = w[PHY_LSB +: PHY_W];
      c.rg  = w[REG_LSB +: REG_W];
      return c;
   endfunction

   function automatic logic [BODY_W-1:0] frame_body(input mdio_cmd_t c,
                                                    input logic [DATA_W-1:0] d);
      logic [1:0] op;
      logic [1:0] ta;
      logic [DATA_W-1:0] dv;
      op = c.wr ? 2'b01 : 2'b10;
      ta = c.wr ? 2'b10 : 2'b11;
      dv = c.wr ? d : {DATA_W{1'b1}};
      return {2'b01, op, c.phy, c.rg, ta, dv};
   endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

   logic [CW-1:0] cnt;
   logic          term;

   assign term     = run && (cnt == LAST);
   assign rise_stb = term && !mdc;
   assign fall_stb = term && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (cnt == LAST) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_flops
         logic [STAGES-1:0] st;
         always_ff @(posedge clk) begin
            if (!rst_n) st <= '1;
            else        st <= STAGES'({st, din});
         end
         assign dout = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_in,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              cap_shift,
   output logic              cap_bit
);
   localparam int FL = PRE_LEN + BODY_W;
   localparam int IW = $clog2(FL);
   localparam logic [IW-1:0] LAST_IDX = IW'(FL - 1);
   localparam logic [IW-1:0] TA_IDX   = IW'(PRE_LEN + HDR_W);
   localparam logic [IW-1:0] DAT_IDX  = IW'(PRE_LEN + HDR_W + 2);

   logic [FL-1:0] frame_q;
   logic [IW-1:0] idx;
   logic          is_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '1;
         idx     <= '0;
         busy    <= 1'b0;
         is_rd   <= 1'b0;
      end else if (start && !busy) begin
         frame_q <= {{PRE_LEN{1'b1}}, frame_body(cmd, wdata)};
         idx     <= '0;
         busy    <= 1'b1;
         is_rd   <= !cmd.wr;
      end else if (busy && fall_stb) begin
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
         end else begin
            idx     <= idx + 1'b1;
            frame_q <= {frame_q[FL-2:0], 1'b1};
         end
      end
   end

   assign mdio_o    = busy ? frame_q[FL-1] : 1'b1;
   assign mdio_oe   = busy && !(is_rd && (idx >= TA_IDX));
   assign cap_shift = busy && rise_stb && is_rd && (idx >= DAT_IDX);
   assign cap_bit   = mdio_in;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
   import mdio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   input  logic              busy,
   input  logic              cap_shift,
   input  logic              cap_bit,
   output logic [DATA_W-1:0] rd_data,
   output logic              start,
   output mdio_cmd_t         cmd_next,
   output mdio_cmd_t         cmd_q,
   output logic [DATA_W-1:0] data_q
);
   logic data_we;

   assign start    = wr_en && wr_sel && !busy;
   assign data_we  = wr_en && !wr_sel && !busy;
   assign cmd_next = decode_ctrl(wr_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         if (start)     cmd_q  <= cmd_next;
         if (data_we)   data_q <= wr_data;
         else if (cap_shift) data_q <= {data_q[DATA_W-2:0], cap_bit};
      end
   end

   logic [DATA_W-1:0] ctrl_rb;
   always_comb begin
      ctrl_rb = '0;
      ctrl_rb[FIN_BIT]               = !busy;
      ctrl_rb[WR_BIT]                = cmd_q.wr;
      ctrl_rb[PHY_LSB +: PHY_W]      = cmd_q.phy;
      ctrl_rb[REG_LSB +: REG_W]      = cmd_q.rg;
   end

   assign rd_data = rd_sel ? ctrl_rb : data_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int PRE_LEN = 32,
   parameter int IN_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   initial begin
      assert (CLK_DIV >= 2) else $error("CLK_DIV must be at least 2");
      assert (IN_SYNC >= 0 && IN_SYNC < CLK_DIV) else $error("IN_SYNC must be below CLK_DIV");
      assert (PRE_LEN >= 1 && PRE_LEN <= 64) else $error("PRE_LEN out of range");
   end

   logic      busy_w, start_w, rise_w, fall_w, cap_shift_w, cap_bit_w, mdio_s;
   mdio_cmd_t cmd_next_w, cmd_rb_w;
   logic [DATA_W-1:0] data_w;

   mdio_host_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .busy(busy_w),
      .cap_shift(cap_shift_w), .cap_bit(cap_bit_w), .rd_data(rd_data),
      .start(start_w), .cmd_next(cmd_next_w), .cmd_q(cmd_rb_w), .data_q(data_w)
   );

   mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy_w), .mdc(mdc),
      .rise_stb(rise_w), .fall_stb(fall_w)
   );

   mdio_in_sync #(.STAGES(IN_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mdio_i), .dout(mdio_s)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start_w), .cmd(cmd_next_w),
      .wdata(data_w), .rise_stb(rise_w), .fall_stb(fall_w), .mdio_in(mdio_s),
      .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .cap_shift(cap_shift_w), .cap_bit(cap_bit_w)
   );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk
   import mdio_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      wr_en,
   input logic      wr_sel,
   input logic      busy,
   input mdio_cmd_t cmd_rb,
   input logic      mdc,
   input logic      mdio_o,
   input logic      mdio_oe
);
   // R4: an accepted control write launches a transfer next cycle
   assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !busy) |=> busy);

   // R8: writes during a transfer leave the latched command alone
   assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> (cmd_rb == $past(cmd_rb)));

   // R6: idle means MDC low and MDIO released
   assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R6: once released inside a transfer, MDIO stays released
   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

   // R7: outputs hold across a rising MDC edge
   assert_rise_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R7: MDC high phase lasts more than one system clock
   assert_high_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |=> mdc);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .busy(busy_w),
   .cmd_rb(cmd_rb_w), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module test_mdio_cmd_ctrl;
   localparam int D   = 4;
   localparam int PRE = 32;
   localparam int FL  = PRE + 32;
   localparam int DUR = 2 * FL * D;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, mdio_i = 1'b1;
   logic [15:0] wr_data = '0, rd_data;
   logic mdc, mdio_o, mdio_oe;

   int vecs = 0, errs = 0;
   int nbits = 0;
   logic [63:0] cap_o, cap_oe;
   logic cur_rd = 1'b0;
   logic [15:0] cur_resp = '0;

   always #10 clk = ~clk;

   mdio_cmd_ctrl #(.CLK_DIV(D), .PRE_LEN(PRE), .IN_SYNC(2)) i_mdio_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model
   always @(posedge mdc) begin
      if (nbits < 64) begin
         cap_o[63-nbits]  = mdio_o;
         cap_oe[63-nbits] = mdio_oe;
      end
      nbits = nbits + 1;
   end
   always @(negedge mdc) begin
      #2;
      if (cur_rd && nbits >= 48 && nbits < 64) mdio_i = cur_resp[15-(nbits-48)];
      else mdio_i = 1'b1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
   endfunction

   function automatic logic [15:0] ctrl_word(input logic wr, input logic [4:0] phy,
                                             input logic [4:0] rg);
      return {2'b00, wr, phy, 3'b000, rg};
   endfunction

   task automatic host_write(input logic sel, input logic [15:0] v);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      rd_sel = sel; #1; v = rd_data;
   endtask

   // val: write data for a write, PHY response for a read
   task automatic do_cmd(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] val, input logic inject);
      logic [15:0] v;
      logic [63:0] ef;
      if (wr) host_write(1'b0, val);
      cur_rd = !wr; cur_resp = val; nbits = 0;
      host_write(1'b1, ctrl_word(wr, phy, rg));
      rd(1'b1, v);
      chk("R4 fin low after launch", {63'd0, v[15]}, 64'd0);
      chk("R1 control readback", {48'd0, v[14:0]}, {49'd0, ctrl_word(wr, phy, rg)[14:0]});
      for (int c = 1; c <= DUR; c++) begin
         @(negedge clk);
         if (inject && c == D) begin
            wr_en = 1'b1; wr_sel = 1'b1; wr_data = ctrl_word(!wr, ~phy, ~rg);
         end else if (inject && c == D + 1) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = ~val;
         end else begin
            wr_en = 1'b0;
         end
         if (c == DUR - 1) begin
            rd(1'b1, v);
            chk("R4 fin low at last busy cycle", {63'd0, v[15]}, 64'd0);
         end
      end
      rd(1'b1, v);
      chk("R4 fin high at due cycle", {63'd0, v[15]}, 64'd1);
      chk("R8 command unchanged", {48'd0, v}, {48'd0, 16'h8000 | ctrl_word(wr, phy, rg)});
      ef = exp_frame(wr, phy, rg, val);
      if (wr) begin
         chk("R2 R3 write frame", cap_o, ef);
         chk("R6 oe for write", cap_oe, {64{1'b1}});
      end else begin
         chk("R2 read frame header", {18'd0, cap_o[63:18]}, {18'd0, ef[63:18]});
         chk("R6 oe for read", cap_oe, {{46{1'b1}}, 18'd0});
      end
      rd(1'b0, v);
      chk(wr ? "R8 data reg kept" : "R5 read data", {48'd0, v}, {48'd0, val});
      repeat (4 * D) @(negedge clk);
      chk("R8 R7 no further MDC edges", 64'(nbits), 64'(FL));
      chk("R6 idle oe low and mdc low", {62'd0, mdio_oe, mdc}, 64'd0);
   endtask

   initial begin
      logic [15:0] v;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R9 mdc/oe in reset", {62'd0, mdc, mdio_oe}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1'b0, v); chk("R9 data reset", {48'd0, v}, 64'd0);
      rd(1'b1, v); chk("R9 control reset", {48'd0, v}, 64'h8000);
      chk("R9 lines idle", {62'd0, mdc, mdio_oe}, 64'd0);
      // directed corners
      do_cmd(1'b0, 5'd0,  5'd0,  16'h0000, 1'b0);
      do_cmd(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b1);
      do_cmd(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
      do_cmd(1'b1, 5'd0,  5'd0,  16'h0000, 1'b1);
      do_cmd(1'b0, 5'd21, 5'd10, 16'hA5C3, 1'b0);
      do_cmd(1'b1, 5'd10, 5'd21, 16'h5A3C, 1'b1);
      // random mix
      for (int i = 0; i < 28; i++) begin
         logic [31:0] r;
         r = $urandom;
         do_cmd(r[0], r[5:1], r[10:6], r[31:16], r[11]);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule